// File: doc/BRIEF.md
# Cluster Event and Barrier Unit

This block coordinates a group of cores that share one memory. Every core owns a small set of event lines held in its own sticky pending buffer, plus an enable mask that picks which of those lines may wake it. When a core asks to wait, it is answered at once if a masked line is already pending. Otherwise the unit drops that core's clock-enable and keeps it low until a masked line arrives. Events come from two sources. Any core may post a software event onto a chosen line for any subset of cores, named by a target bitmask. The hardware barrier posts the other kind.

The barrier holds a programmable participant set and records one arrival bit per participating core. When the recorded arrivals equal the set, the barrier completes. It posts the barrier line into the buffer of every participant and clears its arrival record on the same edge, so the next round can start at once. Participants sleeping on the barrier line resume one edge later, and no memory traffic is involved. All per-core requests use plain request/acknowledge pairs. A request is held high until its acknowledge appears, the acknowledge is a one-cycle pulse, and the core drops the request in the cycle it sees the acknowledge. There is no data stream, so no valid/ready back-pressure applies.

Top module: `cluster_sync_unit`

## Requirements
- R1: After reset every clock-enable is 1, every acknowledge is 0, every event buffer is empty, every mask is all ones and the participant set is empty, so arrivals cannot complete a barrier.
- R2: A wait request sampled while the buffer holds a bit that the mask enables is acknowledged one cycle later, the clock-enable stays 1, the enabled pending bits are cleared, and pending bits the mask disables are kept.
- R3: A wait request sampled with no enabled bit pending drives that core's clock-enable to 0 from the next edge, with no acknowledge for as long as no enabled bit is pending.
- R4: A sleeping core whose buffer gains an enabled bit has its clock-enable return to 1, together with a one-cycle wait acknowledge, at the first edge after the bit enters the buffer.
- R5: Events on lines that a core's mask disables do not wake that core.
- R6: A trigger request from any core with a target bitmask (bit k names core k) and a line index sets that line in the buffer of every targeted core at the edge that samples it. The trigger acknowledge pulses for one cycle.
- R7: An arrival request is acknowledged for one cycle, one cycle after it is sampled. A participant's arrival is recorded, and the barrier completes at the edge where the recorded arrivals, including new ones, equal a non-empty participant set.
- R8: On completion, line 0 (the barrier line) is set in every participant's buffer at the edge that samples the last arrival. Sleeping participants waiting on it resume exactly two edges after the last arrival is sampled, so the latency is within 6 cycles. No participant resumes earlier, and non-participants are not woken.
- R9: The arrival record is cleared on the completion edge, so a following round completes on its own set of arrivals.
- R10: Arrivals from cores outside the participant set are acknowledged but not recorded, and they neither block nor cause completion.
- R11: Writing the participant set discards all recorded arrivals.
- R12: A mask write loads a new enable mask for each core whose mask-write bit is set, and it affects the next wait decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_we | input | NUM_CORES | Per-core mask write strobe |
| mask_wdata | input | EVT_LINES | Mask value written to every strobed core |
| part_we | input | 1 | Participant set write strobe |
| part_wdata | input | NUM_CORES | New participant set, bit k is core k |
| arrive_req | input | NUM_CORES | Per-core barrier arrival request |
| arrive_ack | output | NUM_CORES | Per-core arrival acknowledge pulse |
| wait_req | input | NUM_CORES | Per-core wait-for-event request |
| wait_ack | output | NUM_CORES | Per-core wait acknowledge pulse |
| trig_req | input | NUM_CORES | Per-core software event request |
| trig_target | input | NUM_CORES*NUM_CORES | Target bitmask of core s at bits s*NUM_CORES upward |
| trig_line | input | NUM_CORES*LINE_W | Line index of core s at bits s*LINE_W upward |
| trig_ack | output | NUM_CORES | Per-core trigger acknowledge pulse |
| clk_en | output | NUM_CORES | Per-core clock-enable, 0 while sleeping |

## Verification
A wrong arrival record shows up as a barrier that completes one round early or never completes. It becomes visible at a sleeping participant's clock-enable within two edges of the arrival that should, or should not, have finished the round. A corrupted event buffer or mask shows as a wait that is acknowledged when it should sleep, or the reverse, one cycle after the wait is sampled. A lost wake shows as a clock-enable still low one edge after an enabled event was posted. Both conditions are checked at the exact edges given in the requirements.

// File: rtl/csu_pkg.sv
package csu_pkg;
  typedef enum logic {SLOT_RUN = 1'b0, SLOT_SLEEP = 1'b1} slot_state_e;
endpackage

// File: rtl/csu_slot.sv
module csu_slot
  import csu_pkg::*;
#(
  parameter int EVT_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mask_we,
  input  logic [EVT_LINES-1:0] mask_wdata,
  input  logic [EVT_LINES-1:0] set_in,
  input  logic                 wait_req,
  output logic                 wait_ack,
  output logic                 clk_en,
  output logic [EVT_LINES-1:0] evt_q,
  output logic [EVT_LINES-1:0] mask_q
);
  slot_state_e         st_q;
  logic                hit;
  logic                take;
  logic [EVT_LINES-1:0] clr;

  always_comb begin
    hit  = |(evt_q & mask_q);
    take = wait_req && !wait_ack;
    clr  = (take && hit) ? mask_q : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SLOT_RUN;
      wait_ack <= 1'b0;
      evt_q    <= '0;
      mask_q   <= '1;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      // new events win over the clear so none is lost
      evt_q    <= (evt_q & ~clr) | set_in;
      wait_ack <= take && hit;
      if (take) st_q <= hit ? SLOT_RUN : SLOT_SLEEP;
    end
  end

  assign clk_en = (st_q == SLOT_RUN);
endmodule

// File: rtl/csu_trig_fanin.sv
module csu_trig_fanin #(
  parameter int NUM_CORES = 16,
  parameter int EVT_LINES = 4,
  parameter int LINE_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CORES-1:0]           trig_req,
  input  logic [NUM_CORES*NUM_CORES-1:0] trig_target,
  input  logic [NUM_CORES*LINE_W-1:0]    trig_line,
  output logic [NUM_CORES-1:0]           trig_ack,
  output logic [NUM_CORES*EVT_LINES-1:0] set_vec
);
  logic [NUM_CORES-1:0] trig_new;
  logic [EVT_LINES-1:0] line_oh [NUM_CORES];

  assign trig_new = trig_req & ~trig_ack;

  always_comb begin
    for (int s = 0; s < NUM_CORES; s++) begin
      line_oh[s] = EVT_LINES'(1) << trig_line[s*LINE_W +: LINE_W];
    end
    set_vec = '0;
    for (int s = 0; s < NUM_CORES; s++) begin
      for (int t = 0; t < NUM_CORES; t++) begin
        if (trig_new[s] && trig_target[s*NUM_CORES + t]) begin
          set_vec[t*EVT_LINES +: EVT_LINES] = set_vec[t*EVT_LINES +: EVT_LINES] | line_oh[s];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trig_ack <= '0;
    else        trig_ack <= trig_new;
  end
endmodule

// File: rtl/csu_barrier.sv
module csu_barrier #(
  parameter int NUM_CORES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 part_we,
  input  logic [NUM_CORES-1:0] part_wdata,
  input  logic [NUM_CORES-1:0] arrive_req,
  output logic [NUM_CORES-1:0] arrive_ack,
  output logic [NUM_CORES-1:0] part_q,
  output logic [NUM_CORES-1:0] arr_q,
  output logic                 fire
);
  logic [NUM_CORES-1:0] arr_new;
  logic [NUM_CORES-1:0] arr_acc;

  always_comb begin
    arr_new = arrive_req & ~arrive_ack;
    arr_acc = arr_q | (arr_new & part_q);
    fire    = !part_we && (part_q != '0) && (arr_acc == part_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part_q     <= '0;
      arr_q      <= '0;
      arrive_ack <= '0;
    end else begin
      arrive_ack <= arr_new;
      if (part_we) begin
        part_q <= part_wdata;
        arr_q  <= '0;
      end else if (fire) begin
        arr_q  <= '0;
      end else begin
        arr_q  <= arr_acc;
      end
    end
  end
endmodule

// File: rtl/cluster_sync_unit.sv
module cluster_sync_unit #(
  parameter int  NUM_CORES = 16,
  parameter int  EVT_LINES = 4,
  parameter int  BAR_LINE  = 0,
  localparam int LINE_W    = (EVT_LINES > 1) ? $clog2(EVT_LINES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CORES-1:0]           mask_we,
  input  logic [EVT_LINES-1:0]           mask_wdata,
  input  logic                           part_we,
  input  logic [NUM_CORES-1:0]           part_wdata,
  input  logic [NUM_CORES-1:0]           arrive_req,
  output logic [NUM_CORES-1:0]           arrive_ack,
  input  logic [NUM_CORES-1:0]           wait_req,
  output logic [NUM_CORES-1:0]           wait_ack,
  input  logic [NUM_CORES-1:0]           trig_req,
  input  logic [NUM_CORES*NUM_CORES-1:0] trig_target,
  input  logic [NUM_CORES*LINE_W-1:0]    trig_line,
  output logic [NUM_CORES-1:0]           trig_ack,
  output logic [NUM_CORES-1:0]           clk_en
);
  localparam logic [EVT_LINES-1:0] BAR_OH = EVT_LINES'(1) << BAR_LINE;

  logic [NUM_CORES-1:0]           part_q;
  logic [NUM_CORES-1:0]           arr_q;
  logic                           fire;
  logic [NUM_CORES*EVT_LINES-1:0] trig_set;
  logic [NUM_CORES*EVT_LINES-1:0] evt_flat;
  logic [NUM_CORES*EVT_LINES-1:0] mask_flat;

  csu_barrier #(.NUM_CORES(NUM_CORES)) u_bar (
    .clk(clk), .rst_n(rst_n),
    .part_we(part_we), .part_wdata(part_wdata),
    .arrive_req(arrive_req), .arrive_ack(arrive_ack),
    .part_q(part_q), .arr_q(arr_q), .fire(fire)
  );

  csu_trig_fanin #(.NUM_CORES(NUM_CORES), .EVT_LINES(EVT_LINES), .LINE_W(LINE_W)) u_trig (
    .clk(clk), .rst_n(rst_n),
    .trig_req(trig_req), .trig_target(trig_target), .trig_line(trig_line),
    .trig_ack(trig_ack), .set_vec(trig_set)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
    logic [EVT_LINES-1:0] set_i;
    assign set_i = trig_set[i*EVT_LINES +: EVT_LINES] | ((fire && part_q[i]) ? BAR_OH : '0);
    csu_slot #(.EVT_LINES(EVT_LINES)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .mask_we(mask_we[i]), .mask_wdata(mask_wdata),
      .set_in(set_i), .wait_req(wait_req[i]),
      .wait_ack(wait_ack[i]), .clk_en(clk_en[i]),
      .evt_q(evt_flat[i*EVT_LINES +: EVT_LINES]),
      .mask_q(mask_flat[i*EVT_LINES +: EVT_LINES])
    );
  end
endmodule

// File: rtl/csu_checker.sv
module csu_checker #(
  parameter int NUM_CORES = 16,
  parameter int EVT_LINES = 4,
  parameter int BAR_LINE  = 0
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CORES-1:0]           clk_en,
  input logic [NUM_CORES-1:0]           wait_req,
  input logic [NUM_CORES-1:0]           wait_ack,
  input logic [NUM_CORES-1:0]           arrive_ack,
  input logic [NUM_CORES-1:0]           part_q,
  input logic [NUM_CORES-1:0]           arr_q,
  input logic                           fire,
  input logic [NUM_CORES*EVT_LINES-1:0] evt_flat,
  input logic [NUM_CORES*EVT_LINES-1:0] mask_flat
);
  AST_ARR_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_q & ~part_q) == '0); // R10

  AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (arr_q == '0)); // R9

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    AST_BAR_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && part_q[i]) |=> evt_flat[i*EVT_LINES + BAR_LINE]); // R8

    AST_WAKE_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en[i] && wait_req[i] && |(evt_flat[i*EVT_LINES +: EVT_LINES] & mask_flat[i*EVT_LINES +: EVT_LINES]))
      |=> (clk_en[i] && wait_ack[i])); // R4

    AST_ASLEEP_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en[i] |-> !wait_ack[i]); // R3

    AST_ARR_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      arrive_ack[i] |=> !arrive_ack[i]); // R7
  end
endmodule

bind cluster_sync_unit csu_checker #(
  .NUM_CORES(NUM_CORES), .EVT_LINES(EVT_LINES), .BAR_LINE(BAR_LINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wait_req(wait_req),
  .wait_ack(wait_ack), .arrive_ack(arrive_ack), .part_q(part_q),
  .arr_q(arr_q), .fire(fire), .evt_flat(evt_flat), .mask_flat(mask_flat)
);

// File: tb/cluster_sync_unit_tb.sv
module cluster_sync_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int E  = 4;
  localparam int LW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   mask_we = '0;
  logic [E-1:0]   mask_wdata = '0;
  logic           part_we = 1'b0;
  logic [N-1:0]   part_wdata = '0;
  logic [N-1:0]   arrive_req = '0;
  logic [N-1:0]   arrive_ack;
  logic [N-1:0]   wait_req = '0;
  logic [N-1:0]   wait_ack;
  logic [N-1:0]   trig_req = '0;
  logic [N*N-1:0] trig_target = '0;
  logic [N*LW-1:0] trig_line = '0;
  logic [N-1:0]   trig_ack;
  logic [N-1:0]   clk_en;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_sync_unit #(.NUM_CORES(N), .EVT_LINES(E), .BAR_LINE(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .part_we(part_we), .part_wdata(part_wdata),
    .arrive_req(arrive_req), .arrive_ack(arrive_ack),
    .wait_req(wait_req), .wait_ack(wait_ack),
    .trig_req(trig_req), .trig_target(trig_target), .trig_line(trig_line),
    .trig_ack(trig_ack), .clk_en(clk_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_trig(input int src, input logic [N-1:0] tgt, input int line);
    trig_req[src] = 1'b1;
    trig_target[src*N +: N] = tgt;
    trig_line[src*LW +: LW] = LW'(line);
    tick();
    chk(trig_ack[src] == 1'b1, "R6 trig ack", int'(trig_ack[src]), 1);
    trig_req[src] = 1'b0;
  endtask

  task automatic do_arrive(input int c);
    arrive_req[c] = 1'b1;
    tick();
    chk(arrive_ack[c] == 1'b1, "R7 arrive ack", int'(arrive_ack[c]), 1);
    arrive_req[c] = 1'b0;
  endtask

  task automatic set_part(input logic [N-1:0] v);
    part_we = 1'b1;
    part_wdata = v;
    tick();
    part_we = 1'b0;
  endtask

  task automatic set_mask(input int c, input logic [E-1:0] m);
    mask_we[c] = 1'b1;
    mask_wdata = m;
    tick();
    mask_we[c] = 1'b0;
  endtask

  task automatic t_reset();
    chk(clk_en == '1, "R1 clk_en", int'(clk_en), 16'hFFFF);
    chk(wait_ack == '0 && arrive_ack == '0 && trig_ack == '0, "R1 acks", int'(wait_ack | arrive_ack | trig_ack), 0);
    do_arrive(0);
    wait_req[0] = 1'b1;
    tick();
    chk(clk_en[0] == 1'b0 && wait_ack[0] == 1'b0, "R1 empty set no fire / R3 sleep", int'(clk_en[0]), 0);
    tick();
    tick();
    chk(clk_en[0] == 1'b0 && wait_ack[0] == 1'b0, "R3 stays asleep", int'(clk_en[0]), 0);
    do_trig(1, N'(1), 2);
    chk(clk_en[0] == 1'b0, "R4 not before event edge", int'(clk_en[0]), 0);
    tick();
    chk(clk_en[0] == 1'b1 && wait_ack[0] == 1'b1, "R4 wake one edge after event", int'(clk_en[0]), 1);
    wait_req[0] = 1'b0;
    tick();
    chk(wait_ack[0] == 1'b0, "R4 ack is one pulse", int'(wait_ack[0]), 0);
  endtask

  task automatic t_pending();
    do_trig(3, 16'h0030, 1);
    wait_req[4] = 1'b1;
    tick();
    chk(wait_ack[4] == 1'b1 && clk_en[4] == 1'b1, "R2 pending wait returns", int'(wait_ack[4]), 1);
    wait_req[4] = 1'b0;
    tick();
    wait_req[4] = 1'b1;
    tick();
    chk(clk_en[4] == 1'b0 && wait_ack[4] == 1'b0, "R2 pending bit cleared", int'(clk_en[4]), 0);
    do_trig(7, 16'h0010, 3);
    tick();
    chk(clk_en[4] == 1'b1 && wait_ack[4] == 1'b1, "R4 R6 line3 wake", int'(clk_en[4]), 1);
    wait_req[4] = 1'b0;
    tick();
  endtask

  task automatic t_mask();
    set_mask(5, 4'b0100);
    wait_req[5] = 1'b1;
    tick();
    chk(clk_en[5] == 1'b0, "R5 R12 unmasked pending line1 ignored", int'(clk_en[5]), 0);
    do_trig(0, 16'h0020, 0);
    tick();
    tick();
    chk(clk_en[5] == 1'b0 && wait_ack[5] == 1'b0, "R5 unmasked line0 no wake", int'(clk_en[5]), 0);
    do_trig(0, 16'h0020, 2);
    chk(clk_en[5] == 1'b0, "R4 wake not early", int'(clk_en[5]), 0);
    tick();
    chk(clk_en[5] == 1'b1 && wait_ack[5] == 1'b1, "R4 R12 masked line2 wakes", int'(clk_en[5]), 1);
    wait_req[5] = 1'b0;
    tick();
    set_mask(5, 4'b0010);
    wait_req[5] = 1'b1;
    tick();
    chk(wait_ack[5] == 1'b1 && clk_en[5] == 1'b1, "R2 R12 unmasked line1 kept", int'(wait_ack[5]), 1);
    wait_req[5] = 1'b0;
    tick();
    set_mask(5, 4'hF);
  endtask

  task automatic t_barrier();
    set_part(16'h0007);
    do_arrive(0);
    do_arrive(1);
    wait_req[0] = 1'b1;
    wait_req[1] = 1'b1;
    wait_req[3] = 1'b1;
    tick();
    chk(clk_en[1:0] == 2'b00 && clk_en[3] == 1'b0, "R3 R7 participants asleep", int'(clk_en[3:0]), 4);
    arrive_req[2] = 1'b1;
    tick();
    chk(arrive_ack[2] == 1'b1, "R7 last arrive ack", int'(arrive_ack[2]), 1);
    chk(clk_en[1:0] == 2'b00, "R8 no resume before completion", int'(clk_en[1:0]), 0);
    arrive_req[2] = 1'b0;
    tick();
    chk(clk_en[1:0] == 2'b11 && wait_ack[1:0] == 2'b11, "R8 resume two edges after last arrival", int'(clk_en[1:0]), 3);
    chk(clk_en[3] == 1'b0, "R8 non-participant stays asleep", int'(clk_en[3]), 0);
    wait_req[0] = 1'b0;
    wait_req[1] = 1'b0;
    tick();
    wait_req[2] = 1'b1;
    tick();
    chk(wait_ack[2] == 1'b1 && clk_en[2] == 1'b1, "R8 barrier line posted to last arriver", int'(wait_ack[2]), 1);
    wait_req[2] = 1'b0;
    tick();
    do_arrive(0);
    wait_req[0] = 1'b1;
    tick();
    chk(clk_en[0] == 1'b0, "R9 new round not yet complete", int'(clk_en[0]), 0);
    do_arrive(1);
    tick();
    chk(clk_en[0] == 1'b0, "R9 two of three arrived", int'(clk_en[0]), 0);
    do_arrive(2);
    tick();
    chk(clk_en[0] == 1'b1 && wait_ack[0] == 1'b1, "R9 second round completes", int'(clk_en[0]), 1);
    wait_req[0] = 1'b0;
    do_trig(6, 16'h0008, 1);
    tick();
    chk(clk_en[3] == 1'b1, "R6 non-participant woken by trigger", int'(clk_en[3]), 1);
    wait_req[3] = 1'b0;
    tick();
  endtask

  task automatic t_part_rewrite();
    set_part(16'h0300);
    do_arrive(8);
    set_part(16'h0300);
    do_arrive(5);
    wait_req[8] = 1'b1;
    tick();
    chk(clk_en[8] == 1'b0, "R3 core8 asleep", int'(clk_en[8]), 0);
    do_arrive(9);
    tick();
    chk(clk_en[8] == 1'b0, "R11 rewrite discarded arrival", int'(clk_en[8]), 0);
    do_arrive(8);
    tick();
    chk(clk_en[8] == 1'b1 && wait_ack[8] == 1'b1, "R10 outsider ignored, barrier completes", int'(clk_en[8]), 1);
    wait_req[8] = 1'b0;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_pending();
    t_mask();
    t_barrier();
    t_part_rewrite();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end
endmodule